// File: doc/BRIEF.md
# Speculative Return Address Stack

This block predicts the targets of return instructions in a fetch pipeline that runs ahead of resolution. A call pushes its return address together with an instruction tag. A return pops the top entry. The address of the top entry is always visible on a peek output, so fetch can redirect without changing the stack. Storage is a circular buffer of `DEPTH` slots. When the buffer is full, a push silently reuses the slot of the oldest entry instead of refusing the call.

Whenever a push or pop is accepted, the block returns a snapshot of the entry that operation displaced. The pipeline keeps that snapshot with the speculative instruction. If the instruction is later squashed, the pipeline sends the snapshot back with an undo-push or undo-pop command, and the stack returns to exactly the state it had before. Two saturating counters record how often the oldest entry was discarded and how often a pop found the stack empty. Working out when a squash is needed is the job of the surrounding pipeline.

Top module: `ras_spec_stack`

## Requirements
- R1: After synchronous reset the stack is empty, `peek_addr` is 0 and both event counters read 0.
- R2: A push (`cmd_op`=0) stores `cmd_tag` and `cmd_addr` in the slot at the top. From the next cycle, `peek_addr` shows the most recently pushed address that has not been removed (last-in, first-out).
- R3: In the cycle a push is presented, `snap_valid`=1 and `snap_idx_ok`=1. `snap_idx` is the slot being written, and `snap_tag`/`snap_addr` hold that slot's previous contents. A slot never written since reset reads as all zero.
- R4: A pop (`cmd_op`=1) on a non-empty stack presents the top entry and its slot on the snapshot outputs with `snap_idx_ok`=1. The entry below it then becomes the top.
- R5: A pop on an empty stack presents tag 0, address 0 and `snap_idx_ok`=0. It adds one to `underflow_cnt` and leaves the stack unchanged.
- R6: A push onto a stack holding `DEPTH` entries discards the oldest entry and reuses its slot. The snapshot shows the discarded entry, `overflow_cnt` goes up by one, and the occupancy stays at `DEPTH`.
- R7: An undo-push (`cmd_op`=2) writes `cmd_tag`/`cmd_addr` into the top slot and then removes that entry from the stack. On an empty stack it has no effect.
- R8: An undo-pop (`cmd_op`=3) pushes `cmd_tag`/`cmd_addr` back as the new top. On a full stack it has no effect.
- R9: Each event counter stops at its all-ones value.
- R10: `peek_addr` is 0 whenever the stack is empty.
- R11: `snap_valid` is 0 in idle cycles and during undo commands. An idle cycle (`cmd_valid`=0) changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | A command is presented this cycle |
| cmd_op | input | 2 | 0 push, 1 pop, 2 undo-push, 3 undo-pop |
| cmd_tag | input | TAG_W | Tag for a push, or the snapshot tag for an undo |
| cmd_addr | input | ADDR_W | Address for a push, or the snapshot address for an undo |
| peek_addr | output | ADDR_W | Address of the top entry, 0 when empty |
| snap_valid | output | 1 | The snapshot outputs are meaningful this cycle |
| snap_idx_ok | output | 1 | 0 when a pop found the stack empty |
| snap_idx | output | IDX_W | Slot the snapshot came from |
| snap_tag | output | TAG_W | Displaced tag |
| snap_addr | output | ADDR_W | Displaced address |
| overflow_cnt | output | CNT_W | Saturating count of oldest-entry drops |
| underflow_cnt | output | CNT_W | Saturating count of pops on an empty stack |

## Verification
The bench checks that an undo-push really writes the old contents back. It does this by pushing into the same slot again and comparing the snapshot. A design that only moved the pointer would return the squashed entry there. On the full-stack push, the bench expects the oldest entry on the snapshot outputs. A design that refused the push, or kept the newest entry, would show a wrong peek address and a wrong pop order afterwards. The bench also sends an undo-pop to a full stack and an undo-push to an empty one; a design that failed to ignore them would move the top. Finally, the bench drives both counters past their limit; a design that wraps instead of stopping would read back small values.

// File: rtl/ras_pkg.sv
package ras_pkg;
  typedef enum logic [1:0] {
    RAS_PUSH      = 2'd0,
    RAS_POP       = 2'd1,
    RAS_UNDO_PUSH = 2'd2,
    RAS_UNDO_POP  = 2'd3
  } ras_op_e;
endpackage

// File: rtl/ras_ptr_ctrl.sv
// Top-of-stack pointer and occupancy. The oldest entry is implied by tail and occupancy.
module ras_ptr_ctrl #(
  parameter int DEPTH = 16,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int OCC_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_valid,
  input  logic [1:0]       cmd_op,
  output logic [IDX_W-1:0] tail,
  output logic [IDX_W-1:0] top_idx,
  output logic [OCC_W-1:0] occ,
  output logic             is_full,
  output logic             is_empty,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_idx,
  output logic             ovf_evt,
  output logic             unf_evt
);
  import ras_pkg::*;

  localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

  logic do_push, do_pop, do_undo_push, do_undo_pop;
  logic [IDX_W-1:0] tail_inc;

  assign is_full  = (occ == OCC_W'(DEPTH));
  assign is_empty = (occ == '0);

  assign tail_inc = (tail == LAST) ? '0 : tail + 1'b1;
  assign top_idx  = (tail == '0) ? LAST : tail - 1'b1;

  always_comb begin
    do_push      = cmd_valid && (cmd_op == RAS_PUSH);
    do_pop       = cmd_valid && (cmd_op == RAS_POP) && !is_empty;
    do_undo_push = cmd_valid && (cmd_op == RAS_UNDO_PUSH) && !is_empty;
    do_undo_pop  = cmd_valid && (cmd_op == RAS_UNDO_POP) && !is_full;
    ovf_evt      = do_push && is_full;
    unf_evt      = cmd_valid && (cmd_op == RAS_POP) && is_empty;
    wr_en        = do_push || do_undo_push || do_undo_pop;
    wr_idx       = do_undo_push ? top_idx : tail;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tail <= '0;
      occ  <= '0;
    end else if (do_push || do_undo_pop) begin
      tail <= tail_inc;
      if (!is_full) occ <= occ + 1'b1;
    end else if (do_pop || do_undo_push) begin
      tail <= top_idx;
      occ  <= occ - 1'b1;
    end
  end
endmodule

// File: rtl/ras_store.sv
// Entry storage: one write port, two asynchronous read ports; slots read zero until first written.
module ras_store #(
  parameter int DEPTH  = 16,
  parameter int TAG_W  = 16,
  parameter int ADDR_W = 32,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int ENT_W = TAG_W + ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [IDX_W-1:0]  ra_idx,
  output logic [TAG_W-1:0]  ra_tag,
  output logic [ADDR_W-1:0] ra_addr,
  input  logic [IDX_W-1:0]  rb_idx,
  output logic [TAG_W-1:0]  rb_tag,
  output logic [ADDR_W-1:0] rb_addr
);
  logic [ENT_W-1:0] mem [DEPTH];
  logic [DEPTH-1:0] seen;
  logic [ENT_W-1:0] ra_word, rb_word;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= {wr_tag, wr_addr};
  end

  always_ff @(posedge clk) begin
    if (rst) seen <= '0;
    else if (wr_en) seen[wr_idx] <= 1'b1;
  end

  assign ra_word = seen[ra_idx] ? mem[ra_idx] : '0;
  assign rb_word = seen[rb_idx] ? mem[rb_idx] : '0;
  assign {ra_tag, ra_addr} = ra_word;
  assign {rb_tag, rb_addr} = rb_word;
endmodule

// File: rtl/ras_sat_ctr.sv
module ras_sat_ctr #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  output logic [W-1:0] value
);
  always_ff @(posedge clk) begin
    if (rst) value <= '0;
    else if (inc && (value != '1)) value <= value + 1'b1;
  end
endmodule

// File: rtl/ras_spec_stack.sv
module ras_spec_stack #(
  parameter int DEPTH  = 16,
  parameter int TAG_W  = 16,
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int OCC_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [TAG_W-1:0]  cmd_tag,
  input  logic [ADDR_W-1:0] cmd_addr,
  output logic [ADDR_W-1:0] peek_addr,
  output logic              snap_valid,
  output logic              snap_idx_ok,
  output logic [IDX_W-1:0]  snap_idx,
  output logic [TAG_W-1:0]  snap_tag,
  output logic [ADDR_W-1:0] snap_addr,
  output logic [CNT_W-1:0]  overflow_cnt,
  output logic [CNT_W-1:0]  underflow_cnt
);
  import ras_pkg::*;

  logic [IDX_W-1:0]  tail, top_idx, wr_idx;
  logic [OCC_W-1:0]  occ;
  logic              stk_full, stk_empty, wr_en, ovf_evt, unf_evt;
  logic [TAG_W-1:0]  slot_tag, top_tag;
  logic [ADDR_W-1:0] slot_addr, top_addr;

  ras_ptr_ctrl #(.DEPTH(DEPTH)) u_ptr (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .tail(tail), .top_idx(top_idx), .occ(occ),
    .is_full(stk_full), .is_empty(stk_empty),
    .wr_en(wr_en), .wr_idx(wr_idx), .ovf_evt(ovf_evt), .unf_evt(unf_evt)
  );

  ras_store #(.DEPTH(DEPTH), .TAG_W(TAG_W), .ADDR_W(ADDR_W)) u_store (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_tag(cmd_tag), .wr_addr(cmd_addr),
    .ra_idx(tail), .ra_tag(slot_tag), .ra_addr(slot_addr),
    .rb_idx(top_idx), .rb_tag(top_tag), .rb_addr(top_addr)
  );

  ras_sat_ctr #(.W(CNT_W)) u_ovf (.clk(clk), .rst(rst), .inc(ovf_evt), .value(overflow_cnt));
  ras_sat_ctr #(.W(CNT_W)) u_unf (.clk(clk), .rst(rst), .inc(unf_evt), .value(underflow_cnt));

  assign peek_addr = stk_empty ? '0 : top_addr;

  always_comb begin
    snap_valid  = 1'b0;
    snap_idx_ok = 1'b0;
    snap_idx    = '0;
    snap_tag    = '0;
    snap_addr   = '0;
    if (cmd_valid && (cmd_op == RAS_PUSH)) begin
      snap_valid  = 1'b1;
      snap_idx_ok = 1'b1;
      snap_idx    = tail;
      snap_tag    = slot_tag;
      snap_addr   = slot_addr;
    end else if (cmd_valid && (cmd_op == RAS_POP)) begin
      snap_valid = 1'b1;
      if (!stk_empty) begin
        snap_idx_ok = 1'b1;
        snap_idx    = top_idx;
        snap_tag    = top_tag;
        snap_addr   = top_addr;
      end
    end
  end
endmodule

// File: rtl/ras_spec_stack_chk.sv
module ras_spec_stack_chk #(
  parameter int DEPTH  = 16,
  parameter int TAG_W  = 16,
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  localparam int OCC_W = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst,
  input logic              cmd_valid,
  input logic [1:0]        cmd_op,
  input logic [ADDR_W-1:0] cmd_addr,
  input logic [OCC_W-1:0]  occ,
  input logic [ADDR_W-1:0] peek_addr,
  input logic              snap_idx_ok,
  input logic [TAG_W-1:0]  snap_tag,
  input logic [ADDR_W-1:0] snap_addr,
  input logic [CNT_W-1:0]  overflow_cnt,
  input logic [CNT_W-1:0]  underflow_cnt
);
  import ras_pkg::*;

  AST_OCC_BOUND: assert property (@(posedge clk) disable iff (rst)
    occ <= OCC_W'(DEPTH)); // R6

  AST_PUSH_TOP: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == RAS_PUSH) |=> (peek_addr == $past(cmd_addr))); // R2

  AST_EMPTY_POP_SNAP: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == RAS_POP && occ == '0) |->
      (!snap_idx_ok && snap_tag == '0 && snap_addr == '0)); // R5

  AST_FULL_PUSH_OVF: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == RAS_PUSH && occ == OCC_W'(DEPTH) && overflow_cnt != '1) |=>
      (overflow_cnt == CNT_W'($past(overflow_cnt) + 1'b1) && occ == OCC_W'(DEPTH))); // R6

  AST_UNDO_PUSH_EMPTY: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == RAS_UNDO_PUSH && occ == '0) |=> (occ == '0)); // R7

  AST_UNDO_POP_FULL: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == RAS_UNDO_POP && occ == OCC_W'(DEPTH)) |=>
      (occ == OCC_W'(DEPTH) && $stable(peek_addr))); // R8

  AST_CNT_MONO: assert property (@(posedge clk) disable iff (rst)
    (overflow_cnt == '1) |=> (overflow_cnt == '1)); // R9

  AST_UNF_MONO: assert property (@(posedge clk) disable iff (rst)
    (underflow_cnt == '1) |=> (underflow_cnt == '1)); // R9

  AST_EMPTY_PEEK: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == RAS_POP && occ == OCC_W'(1)) |=> (peek_addr == '0)); // R10
endmodule

bind ras_spec_stack ras_spec_stack_chk #(
  .DEPTH(DEPTH), .TAG_W(TAG_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
  .occ(occ), .peek_addr(peek_addr), .snap_idx_ok(snap_idx_ok),
  .snap_tag(snap_tag), .snap_addr(snap_addr),
  .overflow_cnt(overflow_cnt), .underflow_cnt(underflow_cnt)
);

// File: tb/tb_ras_spec_stack.sv
`timescale 1ns/1ps
module tb_ras_spec_stack;
  localparam int D = 4;
  localparam int TW = 8;
  localparam int AW = 16;
  localparam int CW = 3;
  localparam int IW = 2;
  localparam int CMAX = 7;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_valid = 1'b0;
  logic [1:0] cmd_op = 2'd0;
  logic [TW-1:0] cmd_tag = '0;
  logic [AW-1:0] cmd_addr = '0;
  logic [AW-1:0] peek_addr;
  logic snap_valid, snap_idx_ok;
  logic [IW-1:0] snap_idx;
  logic [TW-1:0] snap_tag;
  logic [AW-1:0] snap_addr;
  logic [CW-1:0] overflow_cnt, underflow_cnt;

  always #4 clk = ~clk;

  ras_spec_stack #(.DEPTH(D), .TAG_W(TW), .ADDR_W(AW), .CNT_W(CW)) dut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_tag(cmd_tag), .cmd_addr(cmd_addr), .peek_addr(peek_addr),
    .snap_valid(snap_valid), .snap_idx_ok(snap_idx_ok), .snap_idx(snap_idx),
    .snap_tag(snap_tag), .snap_addr(snap_addr),
    .overflow_cnt(overflow_cnt), .underflow_cnt(underflow_cnt)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // reference model built from the requirements
  logic [TW-1:0] m_tag [D];
  logic [AW-1:0] m_addr [D];
  int m_tail = 0, m_cnt = 0, m_ovf = 0, m_unf = 0;

  // scoreboard of post-command state
  logic [AW-1:0] q_peek [$];
  int q_ovf [$];
  int q_unf [$];
  string q_req [$];

  task automatic chk(input bit ok, input string req, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] m_peek();
    return (m_cnt == 0) ? '0 : m_addr[(m_tail + D - 1) % D];
  endfunction

  task automatic do_cmd(input bit v, input logic [1:0] op, input logic [TW-1:0] t,
                        input logic [AW-1:0] a, input string req);
    bit e_sv, e_ok;
    int e_idx;
    logic [TW-1:0] e_tag;
    logic [AW-1:0] e_addr;
    @(negedge clk);
    #1;
    cmd_valid = v; cmd_op = op; cmd_tag = t; cmd_addr = a;
    e_sv = 1'b0; e_ok = 1'b0; e_idx = 0; e_tag = '0; e_addr = '0;
    if (v) begin
      case (op)
        2'd0: begin
          if (m_cnt == D) begin
            m_cnt--;
            if (m_ovf < CMAX) m_ovf++;
          end
          e_sv = 1; e_ok = 1; e_idx = m_tail; e_tag = m_tag[m_tail]; e_addr = m_addr[m_tail];
          m_tag[m_tail] = t; m_addr[m_tail] = a;
          m_tail = (m_tail + 1) % D; m_cnt++;
        end
        2'd1: begin
          e_sv = 1;
          if (m_cnt == 0) begin
            if (m_unf < CMAX) m_unf++;
          end else begin
            m_tail = (m_tail + D - 1) % D; m_cnt--;
            e_ok = 1; e_idx = m_tail; e_tag = m_tag[m_tail]; e_addr = m_addr[m_tail];
          end
        end
        2'd2: if (m_cnt > 0) begin
          m_tail = (m_tail + D - 1) % D;
          m_tag[m_tail] = t; m_addr[m_tail] = a; m_cnt--;
        end
        default: if (m_cnt < D) begin
          m_tag[m_tail] = t; m_addr[m_tail] = a;
          m_tail = (m_tail + 1) % D; m_cnt++;
        end
      endcase
    end
    #2;
    chk(snap_valid == e_sv, req, "snap_valid", snap_valid, e_sv);
    if (e_sv) begin
      chk(snap_idx_ok == e_ok, req, "snap_idx_ok", snap_idx_ok, e_ok);
      if (e_ok) chk(snap_idx == IW'(e_idx), req, "snap_idx", snap_idx, e_idx);
      chk(snap_tag == e_tag, req, "snap_tag", snap_tag, e_tag);
      chk(snap_addr == e_addr, req, "snap_addr", snap_addr, e_addr);
    end
    q_peek.push_back(m_peek());
    q_ovf.push_back(m_ovf);
    q_unf.push_back(m_unf);
    q_req.push_back(req);
  endtask

  // monitor: compares the state left by the previous command
  always @(negedge clk) begin
    if (q_req.size() > 0) begin
      logic [AW-1:0] ep;
      int eo, eu;
      string r;
      ep = q_peek.pop_front(); eo = q_ovf.pop_front(); eu = q_unf.pop_front(); r = q_req.pop_front();
      chk(peek_addr == ep, r, "peek_addr", peek_addr, ep);
      chk(overflow_cnt == CW'(eo), r, "overflow_cnt", overflow_cnt, eo);
      chk(underflow_cnt == CW'(eu), r, "underflow_cnt", underflow_cnt, eu);
    end
  end

  initial begin
    #400000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < D; i++) begin m_tag[i] = '0; m_addr[i] = '0; end
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk(peek_addr == '0, "R1", "peek_addr", peek_addr, 0);
    chk(overflow_cnt == '0, "R1", "overflow_cnt", overflow_cnt, 0);
    chk(underflow_cnt == '0, "R1", "underflow_cnt", underflow_cnt, 0);

    do_cmd(1, 2'd1, 8'h00, 16'h0000, "R5");   // pop on empty
    do_cmd(1, 2'd0, 8'h11, 16'h0100, "R3");   // push into never-written slot
    do_cmd(1, 2'd0, 8'h22, 16'h0200, "R2");
    do_cmd(1, 2'd1, 8'h00, 16'h0000, "R4");   // pop returns 22/0200
    do_cmd(1, 2'd3, 8'h22, 16'h0200, "R8");   // undo the pop
    do_cmd(1, 2'd2, 8'h00, 16'h0000, "R7");   // undo the earlier push, restoring zeros
    do_cmd(1, 2'd0, 8'h33, 16'h0300, "R7");   // snapshot must show restored zeros
    do_cmd(1, 2'd0, 8'h44, 16'h0400, "R2");
    do_cmd(1, 2'd0, 8'h55, 16'h0500, "R2");
    do_cmd(1, 2'd3, 8'h99, 16'h0999, "R8");   // ignored: full
    do_cmd(1, 2'd0, 8'h66, 16'h0600, "R6");   // drops oldest 11/0100
    do_cmd(0, 2'd0, 8'hAA, 16'h0AAA, "R11");  // idle
    do_cmd(0, 2'd1, 8'h00, 16'h0000, "R11");
    for (int i = 0; i < 4; i++) do_cmd(1, 2'd1, 8'h00, 16'h0000, "R4");
    do_cmd(1, 2'd1, 8'h00, 16'h0000, "R10");  // empty pop, peek stays 0
    do_cmd(1, 2'd2, 8'h77, 16'h0777, "R7");   // ignored: empty
    do_cmd(1, 2'd0, 8'h12, 16'h0123, "R3");   // snapshot of an earlier slot
    do_cmd(1, 2'd2, 8'h00, 16'h0000, "R11");  // undo command: no snapshot
    for (int i = 0; i < 8; i++) do_cmd(1, 2'd1, 8'h00, 16'h0000, "R9");
    for (int i = 0; i < 12; i++) do_cmd(1, 2'd0, 8'(i + 1), 16'(16'h1000 + i), "R9");
    for (int i = 0; i < 3; i++) do_cmd(1, 2'd1, 8'h00, 16'h0000, "R4");
    do_cmd(0, 2'd0, 8'h00, 16'h0000, "R11");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule